// File: doc/BRIEF.md
# Windowed Sync Pulse Frequency Counter

This block measures how often a horizontal sync pulse arrives. It counts rising edges on the sync input inside a counting window of a fixed number of system clock ticks. The window repeats with a slightly longer period, so each period ends with a short idle gap. When a window closes, the edge count is copied into a 13-bit result in one step, and a strobe marks the update for one cycle. The result is presented as an 8-bit upper field and a 5-bit lower field.

A fast-mode input cuts both the window and the period to a quarter of their length, so that a change in line rate shows up four times sooner. In fast mode the reduced count is stored left-aligned in result bits [12:2], which puts it in the same units as a full-length count. The two lowest bits then read as zero. Any change of the mode input abandons the current window and starts timing again with the new length. Counts that do not fit the result saturate instead of wrapping.

The window and period lengths in normal mode are parameters. The fast-mode lengths are derived from them. The sync input is asynchronous and is resynchronised inside the block.

Top module: `sync_freq_counter`

## Requirements
- R1: Reset clears the result to 0, holds resultValid low and selects normal mode. After reset is released, the first resultValid appears WIN_TICKS+1 clock cycles later and reports the edges of that first window.
- R2: In normal mode (fastMode=0), each period of PERIOD_TICKS cycles starts with a counting window of WIN_TICKS cycles. The result is the number of rising edges on hsyncIn within that window, with freqHigh = result[12:5] and freqLow = result[4:0]. A level that stays high is not counted again.
- R3: In fast mode (fastMode=1), the window is WIN_TICKS/4 cycles and the period is PERIOD_TICKS/4 cycles. The count is written to result[12:2], and freqLow[1:0] reads 0.
- R4: A count that exceeds the available bits saturates. The result becomes 8191 in normal mode and 8188 in fast mode (2047 shifted left by 2).
- R5: resultValid is high for exactly one cycle per completed window. freqHigh and freqLow change only in the cycle in which resultValid is high.
- R6: Rising edges that fall in the idle gap between the end of a window and the start of the next do not contribute to any result.
- R7: A change of fastMode discards the window in progress, and no result is produced for it. Timing restarts, and the next resultValid follows the change by the new window length plus 2 cycles, reporting only edges that arrive after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all window timing is counted in its cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| hsyncIn | input | 1 | Asynchronous horizontal sync pulse input |
| fastMode | input | 1 | 1 selects the quarter-length window, 0 the full window |
| freqHigh | output | 8 | Result bits [12:5] |
| freqLow | output | 5 | Result bits [4:0] |
| resultValid | output | 1 | One-cycle strobe when a new result is latched |

## Verification
The bench builds the block with WIN_TICKS=16800 and PERIOD_TICKS=17200, which gives a 4200-cycle fast window and a 100-cycle fast idle gap. With these lengths a sync input toggling every clock can push past 8191 edges in a normal window and past 2047 edges in a fast window. Both saturation limits can therefore be reached in a short run. The idle gaps are long enough to place a burst of pulses entirely outside the window, and the exact restart latency after a mode switch can be counted in cycles.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int RES_W      = 13;
  localparam int HI_W       = 8;
  localparam int LO_W       = 5;
  localparam int FAST_SHIFT = 2;
  localparam int FAST_W     = RES_W - FAST_SHIFT;

  typedef struct packed {
    logic clearCnt;
    logic countEn;
    logic latchRes;
  } sfcStrobes_t;
endpackage

// File: rtl/sfc_control.sv
module sfc_control
  import sfc_pkg::*;
#(
  parameter int WIN_TICKS    = 320000,
  parameter int PERIOD_TICKS = 327680
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fastMode,
  output sfcStrobes_t strobes,
  output logic        modeFast
);
  localparam int FAST_WIN    = WIN_TICKS / 4;
  localparam int FAST_PERIOD = PERIOD_TICKS / 4;
  localparam int PH_W        = $clog2(PERIOD_TICKS + 1);

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] winLen;
  logic [PH_W-1:0] lastPh;
  logic            modeQ;
  logic            modeChange;
  logic            periodEnd;

  always_comb begin
    modeChange       = (fastMode != modeQ);
    winLen           = modeQ ? PH_W'(FAST_WIN) : PH_W'(WIN_TICKS);
    lastPh           = modeQ ? PH_W'(FAST_PERIOD - 1) : PH_W'(PERIOD_TICKS - 1);
    periodEnd        = (phase == lastPh);
    strobes.countEn  = !modeChange && (phase < winLen);
    strobes.latchRes = !modeChange && (phase == winLen);
    strobes.clearCnt = modeChange || periodEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
      modeQ <= 1'b0;
    end else begin
      modeQ <= fastMode;
      if (modeChange || periodEnd) phase <= '0;
      else                         phase <= phase + 1'b1;
    end
  end

  assign modeFast = modeQ;
endmodule

// File: rtl/sfc_datapath.sv
module sfc_datapath
  import sfc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsyncIn,
  input  sfcStrobes_t      strobes,
  input  logic             modeFast,
  output logic [RES_W-1:0] result,
  output logic             resultValid
);
  localparam logic [RES_W-1:0] FULL_CAP = {RES_W{1'b1}};
  localparam logic [RES_W-1:0] FAST_CAP = RES_W'((1 << FAST_W) - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [SYNC_STAGES-1:0] syncNext;
  logic                   prevQ;
  logic                   rise;
  logic [RES_W-1:0]       edgeCnt;
  logic [RES_W-1:0]       capVal;
  logic [RES_W-1:0]       resultQ;
  logic                   validQ;

  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      assign syncNext = hsyncIn;
    end else begin : gSyncChain
      assign syncNext = {syncQ[SYNC_STAGES-2:0], hsyncIn};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= syncNext;
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign rise   = syncQ[SYNC_STAGES-1] & ~prevQ;
  assign capVal = modeFast ? FAST_CAP : FULL_CAP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 edgeCnt <= '0;
    else if (strobes.clearCnt) edgeCnt <= '0;
    else if (strobes.countEn && rise && (edgeCnt < capVal))
      edgeCnt <= edgeCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      validQ  <= 1'b0;
    end else begin
      validQ <= strobes.latchRes;
      if (strobes.latchRes)
        resultQ <= modeFast ? {edgeCnt[FAST_W-1:0], {FAST_SHIFT{1'b0}}} : edgeCnt;
    end
  end

  assign result      = resultQ;
  assign resultValid = validQ;
endmodule

// File: rtl/sync_freq_counter.sv
module sync_freq_counter
  import sfc_pkg::*;
#(
  parameter int WIN_TICKS    = 320000,
  parameter int PERIOD_TICKS = 327680,
  parameter int SYNC_STAGES  = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hsyncIn,
  input  logic            fastMode,
  output logic [HI_W-1:0] freqHigh,
  output logic [LO_W-1:0] freqLow,
  output logic            resultValid
);
  sfcStrobes_t      strobes;
  logic             modeFast;
  logic [RES_W-1:0] result;

  sfc_control #(
    .WIN_TICKS    (WIN_TICKS),
    .PERIOD_TICKS (PERIOD_TICKS)
  ) ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .fastMode (fastMode),
    .strobes  (strobes),
    .modeFast (modeFast)
  );

  sfc_datapath #(
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .hsyncIn     (hsyncIn),
    .strobes     (strobes),
    .modeFast    (modeFast),
    .result      (result),
    .resultValid (resultValid)
  );

  assign freqHigh = result[RES_W-1:LO_W];
  assign freqLow  = result[LO_W-1:0];
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       fastMode,
  input logic [7:0] freqHigh,
  input logic [4:0] freqLow,
  input logic       resultValid
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (!resultValid && freqHigh == 8'd0 && freqLow == 5'd0)); // R1

  AST_FAST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && $past(fastMode) && $past(fastMode, 2)) |-> (freqLow[1:0] == 2'b00)); // R3

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid); // R5

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable({freqHigh, freqLow})); // R5

  AST_NO_VALID_ON_SWITCH: assert property (@(posedge clk) disable iff (!rstN)
    ($past(fastMode) != $past(fastMode, 2)) |-> !resultValid); // R7
endmodule

bind sync_freq_counter sfc_checker chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .fastMode    (fastMode),
  .freqHigh    (freqHigh),
  .freqLow     (freqLow),
  .resultValid (resultValid)
);

// File: tb/sync_freq_counter_tb_top.sv
`timescale 1ns/1ps
module sync_freq_counter_tb_top;
  localparam int WIN    = 16800;
  localparam int PERIOD = 17200;
  localparam int NVEC   = 5;
  // {fastMode, pulse count, expected 13-bit result}
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b0, 16'd37,   13'd37},
    {1'b0, 16'd1,    13'd1},
    {1'b1, 16'd5,    13'd20},
    {1'b1, 16'd13,   13'd52},
    {1'b1, 16'd300,  13'd1200}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hsyncIn = 1'b0;
  logic       fastMode = 1'b0;
  logic [7:0] freqHigh;
  logic [4:0] freqLow;
  logic       resultValid;
  int checks = 0;
  int fails  = 0;
  bit curMode = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sync_freq_counter #(.WIN_TICKS(WIN), .PERIOD_TICKS(PERIOD), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .fastMode(fastMode),
    .freqHigh(freqHigh), .freqLow(freqLow), .resultValid(resultValid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitValid();
    do @(negedge clk); while (!resultValid);
  endtask

  task automatic sendPulses(input int n, input int h);
    for (int p = 0; p < n; p++) begin
      hsyncIn = 1'b1;
      repeat (h) @(negedge clk);
      hsyncIn = 1'b0;
      repeat (h) @(negedge clk);
    end
  endtask

  // from a resultValid sample, move to phase 3 of the next window
  task automatic gapToWindow();
    int g = curMode ? (PERIOD / 4 - WIN / 4 + 2) : (PERIOD - WIN + 2);
    repeat (g) @(negedge clk);
  endtask

  task automatic setMode(input bit m);
    if (m != curMode) begin
      fastMode = m;
      curMode  = m;
      waitValid();
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (4) @(negedge clk);
    check("R1 reset result", {freqHigh, freqLow}, 0);
    check("R1 reset valid", resultValid, 0);
    rstN = 1'b1;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!resultValid);
    check("R1 first valid latency", cyc, WIN + 1);
    check("R1 first result", {freqHigh, freqLow}, 0);

    for (int i = 0; i < NVEC; i++) begin
      setMode(VEC[i][29]);
      gapToWindow();
      sendPulses(int'(VEC[i][28:13]), 3);
      waitValid();
      check(VEC[i][29] ? "R3 fast count" : "R2 normal count",
            {freqHigh, freqLow}, int'(VEC[i][12:0]));
      @(negedge clk);
      check("R5 valid one cycle", resultValid, 0);
    end

    // R3 fast saturation then R4
    gapToWindow();
    sendPulses(2060, 1);
    waitValid();
    check("R4 fast saturation", {freqHigh, freqLow}, 8188);
    check("R3 low bits zero", freqLow[1:0], 0);

    // back to normal
    setMode(1'b0);
    check("R2 result after switch", {freqHigh, freqLow}, 0);

    // R6 pulses in idle gap ignored
    sendPulses(50, 3);
    waitValid();
    check("R6 idle edges ignored", {freqHigh, freqLow}, 0);

    // R4 normal saturation
    gapToWindow();
    sendPulses(8300, 1);
    waitValid();
    check("R4 normal saturation", {freqHigh, freqLow}, 8191);
    check("R2 high field", freqHigh, 255);

    // R7 mode switch mid-window discards partial count
    gapToWindow();
    sendPulses(5, 3);
    fastMode = 1'b1;
    curMode  = 1'b1;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!resultValid);
    check("R7 restart latency", cyc, WIN / 4 + 2);
    check("R7 discarded count", {freqHigh, freqLow}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule